// File: doc/BRIEF.md
# Dual-Port Write-Through Primary Data Cache

This block is the first-level data cache beside a load/store pipeline. It holds 16 KB in 32-byte lines, one line per set, and serves two request ports of 64 bits each. The set is chosen by bits of the virtual address. The tag it compares is the physical tag, which the translation stage supplies in the same cycle. In a cycle it can serve two loads, or one load and one store. Every store it accepts is passed on at once to the next level through a write-through output. A store that misses first brings its line in, so the line is allocated.

A load hit gives its data and a hit flag in the cycle after the request. On a miss the cache holds both ports. A small refill controller then moves through three states. IDLE goes to WAIT when a miss is seen (transition "miss"). WAIT counts out the fixed penalty and goes to FILL when the count ends (transition "penalty elapsed"). FILL reads the line from the lower level one 64-bit beat per cycle, in rising address order. It returns to IDLE after the last beat (transition "line complete") and marks the line valid in that same step. A port that is held keeps its request on its inputs and is served when the hold drops. The data array has no parity or ECC.

Top module: `dcache_dual`

## Requirements
- R1: After reset, no line is valid, and hold_o, ld_hit_o, wt_vld_o and fill_rd_o are all 0.
- R2: A load that hits is accepted in the cycle it is presented. In the next cycle ld_hit_o for that port is 1 and ld_data_o holds the 64-bit word at that address. Two loads that both hit are accepted in the same cycle.
- R3: A load and a store on different ports are accepted in the same cycle. When both ports present stores in one cycle, port 0 is accepted and port 1 is held (hold_o bit 1 = 1) for that one cycle, then accepted.
- R4: A store changes only the bytes whose enable bit is set. Enable bit i covers data bits 8i+7 down to 8i.
- R5: Every accepted store appears on the write-through output in the next cycle, with wt_addr_o = {physical tag, virtual address}, plus the store data and the enables. This holds for store hits and store misses alike. A store miss allocates its line, so a later load of it hits.
- R6: When no refill is active and any presented request misses, both ports are held. The first refill read (fill_rd_o = 1) comes exactly PENALTY cycles after the miss cycle. The missed request is accepted PENALTY+4 cycles after it was first presented.
- R7: A refill issues four consecutive reads at fill_addr_o = {tag, index, beat, 3'b000}, with beat counting 0, 1, 2, 3. The line is valid and hits in the cycle right after the last beat.
- R8: When a load and a store to the same word are accepted in the same cycle, the load returns the data from before the store. A later load returns the stored data.
- R9: A request whose index matches a valid line but whose physical tag differs is a miss. The refill replaces that line.
- R10: The index is virtual address bits [OFF_W +: IDX_W], with OFF_W = 5 at the default line size. Every index holds its own line, so all of them can be resident and hit at once.
- R11: While a refill is in progress, both ports are held, even if the other port's request would hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 2 | Request present, one bit per port |
| req_we_i | input | 2 | 1 = store, 0 = load, per port |
| req_va_i | input | 2 x VA_W | Virtual byte address (index and offset bits) per port |
| req_ptag_i | input | 2 x PTAG_W | Physical tag from translation, per port |
| req_wdata_i | input | 2 x 64 | Store data per port |
| req_be_i | input | 2 x 8 | Store byte enables per port |
| hold_o | output | 2 | Request not taken this cycle; keep it presented |
| ld_hit_o | output | 2 | Load data valid (hit), one cycle after acceptance |
| ld_data_o | output | 2 x 64 | Load data per port |
| wt_vld_o | output | 1 | Write-through store valid |
| wt_addr_o | output | PTAG_W+VA_W | Physical byte address of the store |
| wt_data_o | output | 64 | Store data sent downstream |
| wt_be_o | output | 8 | Store byte enables sent downstream |
| fill_rd_o | output | 1 | Refill beat read strobe |
| fill_addr_o | output | PTAG_W+VA_W | Physical address of the refill beat |
| fill_data_i | input | 64 | Refill beat data, valid in the strobe cycle |

## Verification
The bench goes after five corner cases. The first is a load and a store to the same word in one cycle: a design that wrote before it read would return the new data. The second is two stores in one cycle: a design that took both at once would drop or merge one write-through, and one that held the wrong port would reorder them. The third is refill timing: the bench counts the cycles from the miss to the first beat and checks each beat address, which catches an off-by-one in the penalty counter or beats in the wrong order. The fourth is a tag mismatch at a resident index, and reloading a line after its eviction: if the write-through were lost, that reload would bring back stale data. The fifth is a hit on one port while the other port's refill is in flight: a design that let the hit through would answer early and break the fixed timing. The bench also sweeps every word of every line in a small cache, two loads per cycle, and steps one enable bit at a time through the byte lanes.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_FILL = 2'd2
    } fill_state_e;
endpackage

// File: rtl/dcd_tags.sv
module dcd_tags #(
    parameter int IDX_W  = 9,
    parameter int PTAG_W = 28
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0][IDX_W-1:0]  rd_idx_i,
    input  logic [1:0][PTAG_W-1:0] rd_tag_i,
    output logic [1:0]             hit_o,
    input  logic                   clr_i,
    input  logic [IDX_W-1:0]       clr_idx_i,
    input  logic                   set_i,
    input  logic [IDX_W-1:0]       set_idx_i,
    input  logic [PTAG_W-1:0]      set_tag_i
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_q;
    logic [PTAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (clr_i) valid_q[clr_idx_i] <= 1'b0;
            if (set_i) valid_q[set_idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_i) tag_q[set_idx_i] <= set_tag_i;
    end

    for (genvar p = 0; p < 2; p++) begin : g_cmp
        assign hit_o[p] = valid_q[rd_idx_i[p]] && (tag_q[rd_idx_i[p]] == rd_tag_i[p]);
    end

    // Invalidation comes at miss time and validation at the last beat, never together (R7)
    p_one_tag_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_i && set_i));
endmodule

// File: rtl/dcd_data.sv
module dcd_data #(
    parameter int ADDR_W = 11,
    parameter int DW     = 64
) (
    input  logic                   clk,
    input  logic [1:0][ADDR_W-1:0] rd_addr_i,
    output logic [1:0][DW-1:0]     rd_data_o,
    input  logic                   we_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [DW-1:0]          wr_data_i,
    input  logic [DW/8-1:0]        wr_be_i
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int LANES = DW / 8;

    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        for (int b = 0; b < LANES; b++) begin
            if (we_i && wr_be_i[b]) mem_q[wr_addr_i][b*8 +: 8] <= wr_data_i[b*8 +: 8];
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        assign rd_data_o[p] = mem_q[rd_addr_i[p]];
    end
endmodule

// File: rtl/dcd_refill.sv
module dcd_refill
    import dcd_pkg::*;
#(
    parameter int PENALTY = 8,
    parameter int IDX_W   = 9,
    parameter int PTAG_W  = 28,
    parameter int BEATS   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       miss_i,
    input  logic [IDX_W-1:0]           miss_idx_i,
    input  logic [PTAG_W-1:0]          miss_tag_i,
    output logic                       busy_o,
    output logic                       clr_o,
    output logic                       rd_o,
    output logic [$clog2(BEATS)-1:0]   beat_o,
    output logic [IDX_W-1:0]           line_idx_o,
    output logic [PTAG_W-1:0]          line_tag_o,
    output logic                       done_o
);
    localparam int CNT_W = $clog2(PENALTY);
    localparam int BT_W  = $clog2(BEATS);

    fill_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BT_W-1:0]   beat_q, beat_d;
    logic [IDX_W-1:0]  idx_q;
    logic [PTAG_W-1:0] tag_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        beat_d  = beat_q;
        unique case (state_q)
            FS_IDLE: if (miss_i) begin
                state_d = FS_WAIT;
                cnt_d   = CNT_W'(PENALTY - 2);
            end
            FS_WAIT: if (cnt_q == '0) begin
                state_d = FS_FILL;
                beat_d  = '0;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
            FS_FILL: if (beat_q == BT_W'(BEATS - 1)) begin
                state_d = FS_IDLE;
            end else begin
                beat_d = beat_q + 1'b1;
            end
            default: state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
            beat_q  <= '0;
            idx_q   <= '0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            beat_q  <= beat_d;
            if (state_q == FS_IDLE && miss_i) begin
                idx_q <= miss_idx_i;
                tag_q <= miss_tag_i;
            end
        end
    end

    always_comb begin
        busy_o     = (state_q != FS_IDLE);
        clr_o      = (state_q == FS_IDLE) && miss_i;
        rd_o       = (state_q == FS_FILL);
        done_o     = (state_q == FS_FILL) && (beat_q == BT_W'(BEATS - 1));
        beat_o     = beat_q;
        line_idx_o = idx_q;
        line_tag_o = tag_q;
    end

    // Beats only start after the penalty wait (R6)
    p_fill_after_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_o) |-> $past(state_q) == FS_WAIT);
    // The last beat releases the controller (R7)
    p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

// File: rtl/dcache_dual.sv
module dcache_dual
    import dcd_pkg::*;
#(
    parameter int CACHE_BYTES = 16384,
    parameter int LINE_BYTES  = 32,
    parameter int DW          = 64,
    parameter int PTAG_W      = 28,
    parameter int PENALTY     = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [1:0]                            req_vld_i,
    input  logic [1:0]                            req_we_i,
    input  logic [1:0][$clog2(CACHE_BYTES)-1:0]   req_va_i,
    input  logic [1:0][PTAG_W-1:0]                req_ptag_i,
    input  logic [1:0][DW-1:0]                    req_wdata_i,
    input  logic [1:0][DW/8-1:0]                  req_be_i,
    output logic [1:0]                            hold_o,
    output logic [1:0]                            ld_hit_o,
    output logic [1:0][DW-1:0]                    ld_data_o,
    output logic                                  wt_vld_o,
    output logic [PTAG_W+$clog2(CACHE_BYTES)-1:0] wt_addr_o,
    output logic [DW-1:0]                         wt_data_o,
    output logic [DW/8-1:0]                       wt_be_o,
    output logic                                  fill_rd_o,
    output logic [PTAG_W+$clog2(CACHE_BYTES)-1:0] fill_addr_o,
    input  logic [DW-1:0]                         fill_data_i
);
    localparam int VA_W  = $clog2(CACHE_BYTES);
    localparam int BE_W  = DW / 8;
    localparam int WB_W  = $clog2(BE_W);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = VA_W - OFF_W;
    localparam int BEATS = LINE_BYTES / BE_W;
    localparam int BT_W  = $clog2(BEATS);
    localparam int WA_W  = VA_W - WB_W;

    logic [1:0][IDX_W-1:0] idx;
    logic [1:0][WA_W-1:0]  wa;
    logic [1:0]            hit, pmiss, taken;
    logic [1:0][DW-1:0]    rd_data;
    logic                  busy, clr, f_rd, f_done, miss, both_st, st_take, st_p, m_p;
    logic [BT_W-1:0]       f_beat;
    logic [IDX_W-1:0]      f_idx;
    logic [PTAG_W-1:0]     f_tag;
    logic                  d_we;
    logic [WA_W-1:0]       d_addr;
    logic [DW-1:0]         d_data;
    logic [BE_W-1:0]       d_be;

    for (genvar p = 0; p < 2; p++) begin : g_port
        assign idx[p] = req_va_i[p][OFF_W +: IDX_W];
        assign wa[p]  = req_va_i[p][VA_W-1:WB_W];
    end

    assign pmiss    = req_vld_i & ~hit;
    assign miss     = !busy && (|pmiss);
    assign both_st  = &(req_vld_i & req_we_i);
    assign hold_o[0] = busy | miss;
    assign hold_o[1] = busy | miss | both_st;
    assign taken    = req_vld_i & ~hold_o;
    assign st_take  = |(taken & req_we_i);
    assign st_p     = !(taken[0] && req_we_i[0]);
    assign m_p      = !pmiss[0];

    dcd_tags #(.IDX_W(IDX_W), .PTAG_W(PTAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_i  (idx),
        .rd_tag_i  (req_ptag_i),
        .hit_o     (hit),
        .clr_i     (clr),
        .clr_idx_i (idx[m_p]),
        .set_i     (f_done),
        .set_idx_i (f_idx),
        .set_tag_i (f_tag)
    );

    dcd_refill #(.PENALTY(PENALTY), .IDX_W(IDX_W), .PTAG_W(PTAG_W), .BEATS(BEATS)) u_refill (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_i     (miss),
        .miss_idx_i (idx[m_p]),
        .miss_tag_i (req_ptag_i[m_p]),
        .busy_o     (busy),
        .clr_o      (clr),
        .rd_o       (f_rd),
        .beat_o     (f_beat),
        .line_idx_o (f_idx),
        .line_tag_o (f_tag),
        .done_o     (f_done)
    );

    // One shared write port: refill beats and store hits never coincide
    assign d_we   = st_take | f_rd;
    assign d_addr = f_rd ? {f_idx, f_beat} : wa[st_p];
    assign d_data = f_rd ? fill_data_i : req_wdata_i[st_p];
    assign d_be   = f_rd ? {BE_W{1'b1}} : req_be_i[st_p];

    dcd_data #(.ADDR_W(WA_W), .DW(DW)) u_data (
        .clk       (clk),
        .rd_addr_i (wa),
        .rd_data_o (rd_data),
        .we_i      (d_we),
        .wr_addr_i (d_addr),
        .wr_data_i (d_data),
        .wr_be_i   (d_be)
    );

    assign fill_rd_o   = f_rd;
    assign fill_addr_o = {f_tag, f_idx, f_beat, {WB_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_hit_o  <= '0;
            ld_data_o <= '0;
            wt_vld_o  <= 1'b0;
            wt_addr_o <= '0;
            wt_data_o <= '0;
            wt_be_o   <= '0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                ld_hit_o[p] <= taken[p] && !req_we_i[p];
                if (taken[p] && !req_we_i[p]) ld_data_o[p] <= rd_data[p];
            end
            wt_vld_o <= st_take;
            if (st_take) begin
                wt_addr_o <= {req_ptag_i[st_p], req_va_i[st_p]};
                wt_data_o <= req_wdata_i[st_p];
                wt_be_o   <= req_be_i[st_p];
            end
        end
    end

    p_pair_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i == 2'b11 && req_we_i == 2'b11 && !busy) |-> hold_o[1]);
    p_wt_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(taken & req_we_i)) |=> wt_vld_o);
    p_ld_hit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit_o[0] |-> $past(hit[0]));
    p_ld_hit1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit_o[1] |-> $past(hit[1]));
    p_refill_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(|(req_vld_i & ~hit)));
    p_beat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_rd_o && $past(fill_rd_o)) |->
        fill_addr_o[OFF_W-1:WB_W] == BT_W'($past(fill_addr_o[OFF_W-1:WB_W]) + 1'b1));
endmodule

// File: tb/sim_dcache_dual.sv
module sim_dcache_dual;
    localparam int CLK_PERIOD = 10;
    localparam int CB  = 256;
    localparam int LB  = 32;
    localparam int PT  = 4;
    localparam int PEN = 8;
    localparam int VAW = 8;
    localparam int PAW = PT + VAW;

    logic clk = 1'b0;
    logic rst_n;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0]           req_vld_i, req_we_i;
    logic [1:0][VAW-1:0]  req_va_i;
    logic [1:0][PT-1:0]   req_ptag_i;
    logic [1:0][63:0]     req_wdata_i;
    logic [1:0][7:0]      req_be_i;
    logic [1:0]           hold_o, ld_hit_o;
    logic [1:0][63:0]     ld_data_o;
    logic                 wt_vld_o, fill_rd_o;
    logic [PAW-1:0]       wt_addr_o, fill_addr_o;
    logic [63:0]          wt_data_o, fill_data_i;
    logic [7:0]           wt_be_o;

    dcache_dual #(.CACHE_BYTES(CB), .LINE_BYTES(LB), .DW(64), .PTAG_W(PT), .PENALTY(PEN)) u0 (
        .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld_i), .req_we_i(req_we_i),
        .req_va_i(req_va_i), .req_ptag_i(req_ptag_i), .req_wdata_i(req_wdata_i),
        .req_be_i(req_be_i), .hold_o(hold_o), .ld_hit_o(ld_hit_o), .ld_data_o(ld_data_o),
        .wt_vld_o(wt_vld_o), .wt_addr_o(wt_addr_o), .wt_data_o(wt_data_o), .wt_be_o(wt_be_o),
        .fill_rd_o(fill_rd_o), .fill_addr_o(fill_addr_o), .fill_data_i(fill_data_i)
    );

    logic [63:0] lowmem [512];
    logic [63:0] refmem [512];

    assign fill_data_i = lowmem[fill_addr_o[PAW-1:3]];

    always @(posedge clk) begin
        if (wt_vld_o) begin
            for (int b = 0; b < 8; b++)
                if (wt_be_o[b]) lowmem[wt_addr_o[PAW-1:3]][b*8 +: 8] <= wt_data_o[b*8 +: 8];
        end
    end

    int total = 0;
    int bad   = 0;
    int tk [2];
    int ffirst, nb;
    logic hold1_c0;
    logic [6:0] exp_line;

    function automatic logic [63:0] seed(int a);
        return {32'(a) * 32'h9E37_79B1, 32'hC0DE_0000 ^ 32'(a)};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic op(input logic v0, input logic w0, input logic [7:0] a0, input logic [3:0] t0,
                      input logic [63:0] d0, input logic [7:0] e0,
                      input logic v1, input logic w1, input logic [7:0] a1, input logic [3:0] t1,
                      input logic [63:0] d1, input logic [7:0] e1);
        logic [1:0] pend, h, tkn;
        logic       w [2];
        logic [7:0] a [2];
        logic [3:0] t [2];
        logic [63:0] d [2];
        logic [7:0] e [2];
        logic [63:0] exl [2];
        int c = 0;
        w[0] = w0; a[0] = a0; t[0] = t0; d[0] = d0; e[0] = e0;
        w[1] = w1; a[1] = a1; t[1] = t1; d[1] = d1; e[1] = e1;
        req_vld_i = {v1, v0};
        req_we_i  = {w1, w0};
        req_va_i[0] = a0; req_va_i[1] = a1;
        req_ptag_i[0] = t0; req_ptag_i[1] = t1;
        req_wdata_i[0] = d0; req_wdata_i[1] = d1;
        req_be_i[0] = e0; req_be_i[1] = e1;
        pend = {v1, v0};
        tk[0] = -1; tk[1] = -1; ffirst = -1; nb = 0; hold1_c0 = 1'b0;
        while (pend != 2'b00 && c < 100) begin
            #2;
            h = hold_o;
            if (c == 0) hold1_c0 = h[1];
            if (fill_rd_o) begin
                if (nb == 0) ffirst = c;
                chk(fill_addr_o == {exp_line, 2'(nb), 3'b000}, "R7 refill beat address",
                    64'(fill_addr_o), 64'({exp_line, 2'(nb), 3'b000}));
                nb++;
            end
            tkn = pend & ~h;
            for (int p = 0; p < 2; p++)
                if (tkn[p] && !w[p]) exl[p] = refmem[{t[p], a[p][7:3]}];
            @(posedge clk);
            #1;
            for (int p = 0; p < 2; p++) begin
                if (tkn[p]) begin
                    tk[p] = c;
                    if (!w[p]) begin
                        chk(ld_hit_o[p] == 1'b1 && ld_data_o[p] == exl[p], "R2 load data",
                            ld_data_o[p], exl[p]);
                    end else begin
                        chk(wt_vld_o && wt_addr_o == {t[p], a[p]} && wt_data_o == d[p] && wt_be_o == e[p],
                            "R5 write-through", {wt_data_o[51:0], wt_addr_o}, {d[p][51:0], t[p], a[p]});
                        for (int b = 0; b < 8; b++)
                            if (e[p][b]) refmem[{t[p], a[p][7:3]}][b*8 +: 8] = d[p][b*8 +: 8];
                    end
                    req_vld_i[p] = 1'b0;
                end
            end
            pend &= ~tkn;
            c++;
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] old, nw;
        for (int i = 0; i < 512; i++) begin
            lowmem[i] = seed(i);
            refmem[i] = seed(i);
        end
        rst_n = 1'b0;
        req_vld_i = '0; req_we_i = '0; req_va_i = '0; req_ptag_i = '0;
        req_wdata_i = '0; req_be_i = '0;
        exp_line = '0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk(hold_o == 2'b00, "R1 hold after reset", 64'(hold_o), 64'd0);
        chk(ld_hit_o == 2'b00, "R1 ld_hit after reset", 64'(ld_hit_o), 64'd0);
        chk(!wt_vld_o && !fill_rd_o, "R1 wt/fill idle after reset", 64'({wt_vld_o, fill_rd_o}), 64'd0);
        @(posedge clk); #1;

        // R6/R7/R11: cold miss on port 0, port 1 same line waits
        exp_line = {4'd1, 3'd0};
        op(1, 0, 8'h00, 4'd1, 0, 0, 1, 0, 8'h08, 4'd1, 0, 0);
        chk(tk[0] == PEN + 4, "R6 miss acceptance cycle", 64'(tk[0]), 64'(PEN + 4));
        chk(tk[1] == PEN + 4, "R11 other port held through refill", 64'(tk[1]), 64'(PEN + 4));
        chk(ffirst == PEN, "R6 first refill beat timing", 64'(ffirst), 64'(PEN));
        chk(nb == 4, "R7 four refill beats", 64'(nb), 64'd4);
        chk(hold1_c0 == 1'b1, "R6 both ports held in miss cycle", 64'(hold1_c0), 64'd1);

        // R10: fill every index
        for (int k = 1; k < 8; k++) begin
            exp_line = {4'd1, 3'(k)};
            op(1, 0, 8'(k * 32), 4'd1, 0, 0, 0, 0, 0, 0, 0, 0);
            chk(tk[0] == PEN + 4, "R10 index fill", 64'(tk[0]), 64'(PEN + 4));
        end
        // R2/R10: sweep all words, two loads per cycle
        for (int i = 0; i < 32; i++) begin
            op(1, 0, 8'(i * 8), 4'd1, 0, 0, 1, 0, 8'((31 - i) * 8), 4'd1, 0, 0);
            chk(tk[0] == 0 && tk[1] == 0, "R2 two hits served together", 64'({tk[0], tk[1]}), 64'd0);
        end

        // R3: load and store in one cycle, both directions
        op(1, 0, 8'h18, 4'd1, 0, 0, 1, 1, 8'h50, 4'd1, 64'h1111_2222_3333_4444, 8'hFF);
        chk(tk[0] == 0 && tk[1] == 0, "R3 load+store same cycle", 64'({tk[0], tk[1]}), 64'd0);
        op(1, 1, 8'h28, 4'd1, 64'h5555_6666_7777_8888, 8'h0F, 1, 0, 8'h30, 4'd1, 0, 0);
        chk(tk[0] == 0 && tk[1] == 0, "R3 store+load same cycle", 64'({tk[0], tk[1]}), 64'd0);

        // R3: two stores, port 1 held one cycle
        op(1, 1, 8'h20, 4'd1, 64'hAAAA_0000_AAAA_0001, 8'hFF, 1, 1, 8'hA0, 4'd1, 64'hBBBB_0000_BBBB_0002, 8'hFF);
        chk(tk[0] == 0, "R3 port0 store accepted", 64'(tk[0]), 64'd0);
        chk(tk[1] == 1 && hold1_c0 == 1'b1, "R3 port1 store held one cycle", 64'(tk[1]), 64'd1);
        op(1, 0, 8'h20, 4'd1, 0, 0, 1, 0, 8'hA0, 4'd1, 0, 0);
        chk(ld_data_o[1] == 64'hBBBB_0000_BBBB_0002, "R3 held store landed", ld_data_o[1], 64'hBBBB_0000_BBBB_0002);

        // R4: one byte lane at a time
        for (int b = 0; b < 8; b++) begin
            old = refmem[{4'd1, 5'h07}];
            nw  = 64'h0123_4567_89AB_CDEF ^ {8{8'(b * 17 + 3)}};
            op(1, 1, 8'h38, 4'd1, nw, 8'(1 << b), 0, 0, 0, 0, 0, 0);
            op(1, 0, 8'h38, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0);
            old[b*8 +: 8] = nw[b*8 +: 8];
            chk(ld_data_o[0] == old, "R4 byte enable lane", ld_data_o[0], old);
        end

        // R8: same-word load and store in one cycle
        old = refmem[{4'd1, 5'h09}];
        op(1, 0, 8'h48, 4'd1, 0, 0, 1, 1, 8'h48, 4'd1, 64'hDEAD_BEEF_0BAD_F00D, 8'hFF);
        chk(ld_data_o[0] == old, "R8 load sees pre-store data", ld_data_o[0], old);
        op(1, 0, 8'h48, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk(ld_data_o[0] == 64'hDEAD_BEEF_0BAD_F00D, "R8 later load sees store", ld_data_o[0], 64'hDEAD_BEEF_0BAD_F00D);

        // R9: tag mismatch at a resident index
        exp_line = {4'd2, 3'd2};
        op(1, 0, 8'h48, 4'd2, 0, 0, 0, 0, 0, 0, 0, 0);
        chk(tk[0] == PEN + 4, "R9 tag mismatch misses", 64'(tk[0]), 64'(PEN + 4));
        chk(ld_data_o[0] == seed({4'd2, 5'h09}), "R9 replaced line data", ld_data_o[0], seed({4'd2, 5'h09}));
        exp_line = {4'd1, 3'd2};
        op(1, 0, 8'h48, 4'd1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk(tk[0] == PEN + 4, "R9 evicted line misses again", 64'(tk[0]), 64'(PEN + 4));
        chk(ld_data_o[0] == 64'hDEAD_BEEF_0BAD_F00D, "R5 store reached next level", ld_data_o[0], 64'hDEAD_BEEF_0BAD_F00D);

        // R5/R6: store miss allocates
        exp_line = {4'd3, 3'd7};
        op(1, 1, 8'hE8, 4'd3, 64'h7777_1234_5678_9999, 8'hFF, 0, 0, 0, 0, 0, 0);
        chk(tk[0] == PEN + 4 && ffirst == PEN, "R6 store miss timing", 64'(tk[0]), 64'(PEN + 4));
        op(1, 0, 8'hE8, 4'd3, 0, 0, 0, 0, 0, 0, 0, 0);
        chk(tk[0] == 0, "R5 store miss allocated line", 64'(tk[0]), 64'd0);
        chk(ld_data_o[0] == 64'h7777_1234_5678_9999, "R5 allocated line holds store", ld_data_o[0], 64'h7777_1234_5678_9999);

        // R11: hit on port 0 waits while port 1 refills
        exp_line = {4'd5, 3'd3};
        op(1, 0, 8'h18, 4'd1, 0, 0, 1, 0, 8'h60, 4'd5, 0, 0);
        chk(tk[0] == PEN + 4, "R11 hit waits during refill", 64'(tk[0]), 64'(PEN + 4));
        chk(tk[1] == PEN + 4 && nb == 4, "R7 port1 refill served", 64'(tk[1]), 64'(PEN + 4));

        finish_run();
    end
endmodule